// File: doc/BRIEF.md
# Cascade Codec Chain Configuration Master

This block is the host end of a serial ring of cascaded codec channels. The last channel's output frame sync is looped back to the master, where it serves as the receive frame sync and also as the trigger for transmission. The ring drives one frame sync per channel on every sample event. The first pulse of an event starts the master, which then clocks one 16-bit word per channel into the ring. The words go out back-to-back and the frame sync of each word overlaps the last data bit of the word before it. While it transmits, the master deserialises the words that come back.

Bring-up takes the first three sample events, one register per event. Event one writes the clocking register, event two writes the power register, and event three writes the mode register. In every event the same register is written in all channels, and the farthest channel is addressed first. From the fourth event on, the master sends raw DAC samples taken from a parallel input, again with the farthest channel first. It returns each received ADC word on a parallel output, tagged with its channel and marked by a one-cycle strobe. The serial bit clock is the block clock `clk`.

Top module: `cseq_master`

## Requirements
- R1: While reset is held, and after it until the first frame sync, `tx_fs`, `tx_data` and `adc_valid` are 0. `tx_data` is 0 in every cycle that carries no word bit.
- R2: The first `fs_in` pulse of a sample event is sampled at edge E0. `tx_fs` is 1 in the cycle after E0. Word 0 then follows MSB first, one bit per cycle, starting in the next cycle.
- R3: Each event sends exactly NCH words with no gaps. The `tx_fs` pulse of word w+1 is in the same cycle as bit 0 (the LSB) of word w. `tx_fs` is never high for two cycles in a row.
- R4: A control word has the layout bit 15 = 1, bit 14 = 0 (write), bits 13:11 = channel address, bits 10:8 = register code and bits 7:0 = value.
- R5: The channel address is the number of hops from the ring input, which is the 1-based channel number minus 1. Word w of an event is for channel NCH−w, so addresses go out from NCH−1 down to 0.
- R6: Event 1 writes register code 1 (clocking). Event 2 writes code 2 (power). Event 3 writes code 0 (mode). Within one event every channel gets the same register.
- R7: The clocking value is 0x1B: bits 7:5 = 0 (divide by 1), bits 4:3 = 3 (bit clock at half the divided clock), bits 1:0 = 3 (rate of 1/256). The power value is 0x07: bit 0 reference, bit 1 ADC, bit 2 DAC. The mode value has bit 7 = 1 (data mode) and bits 6:4 = NCH, which gives 0xA0 for two channels.
- R8: From event 4 on, word w is the raw 16-bit sample for channel NCH−w. For 1-based channel k the sample is `dac_in[(k-1)*16 +: 16]`, as sampled at E0.
- R9: After each `fs_in` pulse, the next 16 cycles carry one received word on `rx_data`, MSB first. In data events `adc_valid` pulses for one cycle, in the cycle after the LSB, with the word on `adc_out`. Word w of the event is tagged `adc_chan` = NCH−1−w.
- R10: Words received during the three programming events never raise `adc_valid`.
- R11: An `fs_in` pulse that is not the first of its event starts no transmission and leaves the outgoing stream unchanged. Pulses may be 16 or more cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_in | input | 1 | Looped-back ring frame sync (one pulse per word) |
| rx_data | input | 1 | Serial data from the ring |
| dac_in | input | NCH*16 | DAC samples, channel k at bits (k-1)*16 upward |
| tx_data | output | 1 | Serial data into the ring |
| tx_fs | output | 1 | Transmit frame sync, one cycle before each word |
| adc_out | output | 16 | Received ADC word |
| adc_chan | output | CHW | 0-based channel of `adc_out` |
| adc_valid | output | 1 | One-cycle strobe for `adc_out` |

## Verification
The hardest situation to reach is an edge where one event is still sending its last bit while the ring already signals the next event. This is where a badly ordered serialiser would clip or restart a word. The stimulus places the next event's first pulse at the earliest cycle the timing rule allows. It also stretches the pulse spacing inside some events, so that the receive side runs out of step with the back-to-back transmit side. It drives edge-value ADC words such as all ones and a lone MSB through the ring as well.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    PH_CLK  = 2'd0,
    PH_PWR  = 2'd1,
    PH_MODE = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  localparam logic [2:0] SEL_MODE = 3'd0;
  localparam logic [2:0] SEL_CLK  = 3'd1;
  localparam logic [2:0] SEL_PWR  = 3'd2;

  // write-type control word: marker, write, address, register, value
  function automatic logic [WORD_W-1:0] ctrl_word(input logic [2:0] addr,
                                                  input logic [2:0] sel,
                                                  input logic [7:0] val);
    return {1'b1, 1'b0, addr, sel, val};
  endfunction

  // divider code 0 (/1), bit clock code 3 (/2), rate code 3 (/256)
  function automatic logic [7:0] clk_value();
    return {3'd0, 2'd3, 1'b0, 2'd3};
  endfunction

  // dac, adc, reference powered
  function automatic logic [7:0] pwr_value();
    return {5'd0, 1'b1, 1'b1, 1'b1};
  endfunction

  function automatic logic [7:0] mode_value(input int unsigned nch);
    return {1'b1, 3'(nch), 4'd0};
  endfunction

  function automatic phase_t phase_after(input phase_t ph);
    phase_t nx;
    case (ph)
      PH_CLK:  nx = PH_PWR;
      PH_PWR:  nx = PH_MODE;
      default: nx = PH_DATA;
    endcase
    return nx;
  endfunction

endpackage

// File: rtl/cseq_phase.sv
module cseq_phase
  import cseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ev_start,
  output phase_t phase,
  output logic   phase_is_data
);

  logic phase_adv;
  assign phase_adv     = ev_start && (phase != PH_DATA);
  assign phase_is_data = (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n)         phase <= PH_CLK;
    else if (phase_adv) phase <= phase_after(phase);
  end

  // R6: the phase moves only on the edge that opens an event
  assert_phase_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> $past(ev_start));

endmodule

// File: rtl/cseq_words.sv
module cseq_words
  import cseq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  phase_t                  phase,
  input  logic [NCH*WORD_W-1:0]   dac_in,
  output logic [NCH*WORD_W-1:0]   words
);

  for (genvar w = 0; w < NCH; w++) begin : g_word
    localparam int CH = NCH - 1 - w;   // farthest channel first
    always_comb begin
      case (phase)
        PH_CLK:  words[w*WORD_W +: WORD_W] = ctrl_word(3'(CH), SEL_CLK, clk_value());
        PH_PWR:  words[w*WORD_W +: WORD_W] = ctrl_word(3'(CH), SEL_PWR, pwr_value());
        PH_MODE: words[w*WORD_W +: WORD_W] = ctrl_word(3'(CH), SEL_MODE, mode_value(NCH));
        default: words[w*WORD_W +: WORD_W] = dac_in[CH*WORD_W +: WORD_W];
      endcase
    end
  end

endmodule

// File: rtl/cseq_tx.sv
module cseq_tx
  import cseq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_start,
  input  logic [NCH*WORD_W-1:0]   words,
  output logic                    tx_data,
  output logic                    tx_fs
);

  localparam int TOTAL = NCH * WORD_W;
  localparam int PW    = $clog2(TOTAL);
  localparam logic [PW-1:0] LAST_POS  = PW'(TOTAL - 1);
  localparam logic [PW-5:0] LAST_WORD = (PW-4)'(NCH - 1);

  logic [TOTAL-1:0] store;
  logic [PW-1:0]    pos;
  logic             active;
  logic [PW-5:0]    pos_word;
  logic [3:0]       pos_bit;
  logic [PW-1:0]    bit_idx;
  logic             word_end_mid;   // last bit of a word that has a successor
  logic             stream_end;

  assign pos_word     = pos[PW-1:4];
  assign pos_bit      = pos[3:0];
  assign bit_idx      = {pos_word, ~pos_bit};
  assign word_end_mid = active && (pos_bit == 4'hF) && (pos_word != LAST_WORD);
  assign stream_end   = active && (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store   <= '0;
      pos     <= '0;
      active  <= 1'b0;
      tx_data <= 1'b0;
      tx_fs   <= 1'b0;
    end else if (ev_start) begin
      store   <= words;
      pos     <= '0;
      active  <= 1'b1;
      tx_data <= 1'b0;
      tx_fs   <= 1'b1;
    end else if (active) begin
      tx_data <= store[bit_idx];
      tx_fs   <= word_end_mid;
      pos     <= pos + 1'b1;
      if (stream_end) active <= 1'b0;
    end else begin
      tx_data <= 1'b0;
      tx_fs   <= 1'b0;
    end
  end

  // R3: frame sync is a single-cycle pulse
  assert_fs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs |=> !tx_fs);

  // R2: every frame sync is followed by word bits
  assert_fs_has_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fs |-> active);

endmodule

// File: rtl/cseq_rx.sv
module cseq_rx
  import cseq_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CHW = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_in,
  input  logic              rx_data,
  input  logic              phase_is_data,
  output logic              ev_start,
  output logic [WORD_W-1:0] adc_out,
  output logic [CHW-1:0]    adc_chan,
  output logic              adc_valid
);

  localparam logic [CHW-1:0] LAST_IDX = CHW'(NCH - 1);

  logic [CHW-1:0]    word_cnt;
  logic [CHW-1:0]    tag;
  logic              word_data;
  logic              ev_data;
  logic [4:0]        left;
  logic [WORD_W-2:0] sh;
  logic              word_done;

  assign ev_start  = fs_in && (word_cnt == '0);
  assign word_done = (left == 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_cnt  <= '0;
      tag       <= '0;
      word_data <= 1'b0;
      ev_data   <= 1'b0;
      left      <= '0;
      sh        <= '0;
      adc_out   <= '0;
      adc_chan  <= '0;
      adc_valid <= 1'b0;
    end else begin
      adc_valid <= 1'b0;
      if (left != 5'd0) begin
        sh   <= {sh[WORD_W-3:0], rx_data};
        left <= left - 5'd1;
        if (word_done && word_data) begin
          adc_out   <= {sh, rx_data};
          adc_chan  <= tag;
          adc_valid <= 1'b1;
        end
      end
      if (fs_in) begin
        left     <= 5'(WORD_W);
        tag      <= LAST_IDX - word_cnt;
        word_cnt <= (word_cnt == LAST_IDX) ? '0 : word_cnt + 1'b1;
        if (ev_start) begin
          ev_data   <= phase_is_data;
          word_data <= phase_is_data;
        end else begin
          word_data <= ev_data;
        end
      end
    end
  end

  // R10: no sample is reported before the ring is in data mode
  assert_valid_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |-> phase_is_data);

  // R9: the strobe lasts one cycle
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_valid |=> !adc_valid);

endmodule

// File: rtl/cseq_master.sv
module cseq_master
  import cseq_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fs_in,
  input  logic                  rx_data,
  input  logic [NCH*16-1:0]     dac_in,
  output logic                  tx_data,
  output logic                  tx_fs,
  output logic [15:0]           adc_out,
  output logic [CHW-1:0]        adc_chan,
  output logic                  adc_valid
);

  logic                  ev_start;
  phase_t                phase;
  logic                  phase_is_data;
  logic [NCH*WORD_W-1:0] words;

  cseq_phase u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start     (ev_start),
    .phase        (phase),
    .phase_is_data(phase_is_data)
  );

  cseq_words #(.NCH(NCH)) u_words (
    .phase (phase),
    .dac_in(dac_in),
    .words (words)
  );

  cseq_tx #(.NCH(NCH)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_start(ev_start),
    .words   (words),
    .tx_data (tx_data),
    .tx_fs   (tx_fs)
  );

  cseq_rx #(.NCH(NCH), .CHW(CHW)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .fs_in        (fs_in),
    .rx_data      (rx_data),
    .phase_is_data(phase_is_data),
    .ev_start     (ev_start),
    .adc_out      (adc_out),
    .adc_chan     (adc_chan),
    .adc_valid    (adc_valid)
  );

  // R1: outputs stay quiet while reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!tx_fs && !adc_valid));

endmodule

// File: tb/tb_cseq_master.sv
module tb_cseq_master;

  localparam int NCH   = 2;
  localparam int LIMIT = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fs_in = 1'b0;
  logic              rx_data = 1'b0;
  logic [NCH*16-1:0] dac_in = '0;
  logic              tx_data;
  logic              tx_fs;
  logic [15:0]       adc_out;
  logic              adc_chan;
  logic              adc_valid;

  cseq_master #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .fs_in(fs_in), .rx_data(rx_data), .dac_in(dac_in),
    .tx_data(tx_data), .tx_fs(tx_fs), .adc_out(adc_out), .adc_chan(adc_chan),
    .adc_valid(adc_valid)
  );

  always #2 clk = ~clk;   // 250 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int end_cyc = 0;
  int ev_n = 0;
  bit done = 0;

  // stimulus and expectation, keyed by cycle
  bit          stim_fs [int];
  bit          stim_rx [int];
  logic [31:0] stim_dac[int];
  bit          exp_fs  [int];
  bit          exp_d   [int];
  string       exp_tag [int];
  bit          exp_v   [int];
  logic [15:0] exp_adc [int];
  int          exp_ch  [int];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, expv);
    end
  endtask

  // model of one sample event starting with a pulse driven in cycle p
  task automatic add_event(input int p, input int gap, input logic [15:0] w0,
                           input logic [15:0] w1, input logic [31:0] dac);
    logic [15:0] rxw [NCH];
    logic [15:0] txw;
    int ch;
    rxw[0] = w0; rxw[1] = w1;
    stim_dac[p] = dac;
    for (int w = 0; w < NCH; w++) begin
      int q;
      q = p + gap * w;
      stim_fs[q] = 1;
      for (int j = 0; j < 16; j++) stim_rx[q + 1 + j] = rxw[w][15 - j];
      if (ev_n >= 3) begin             // R9 / R10: only data events report
        exp_v[q + 17]   = 1;
        exp_adc[q + 17] = rxw[w];
        exp_ch[q + 17]  = NCH - 1 - w;
      end
      // transmit side, R5: channel NCH-w, address NCH-1-w
      ch = NCH - 1 - w;
      case (ev_n)
        0: txw = {2'b10, 3'(ch), 3'd1, 8'h1B};                       // R6 R7
        1: txw = {2'b10, 3'(ch), 3'd2, 8'h07};                       // R6 R7
        2: txw = {2'b10, 3'(ch), 3'd0, 1'b1, 3'(NCH), 4'h0};         // R6 R7
        default: txw = dac[ch*16 +: 16];                             // R8
      endcase
      exp_fs[p + 1 + 16 * w] = 1;                                    // R2 R3
      for (int j = 0; j < 16; j++) begin
        exp_d[p + 2 + 16 * w + j]   = txw[15 - j];
        exp_tag[p + 2 + 16 * w + j] = (ev_n < 3) ? "R4 R5 R6 R7" : "R8";
      end
    end
    ev_n++;
    if (p + gap * (NCH - 1) + 40 > end_cyc) end_cyc = p + gap * (NCH - 1) + 40;
  endtask

  // drive inputs away from the active edge
  always @(negedge clk) begin
    fs_in   <= stim_fs.exists(cyc) ? 1'b1 : 1'b0;
    rx_data <= stim_rx.exists(cyc) ? stim_rx[cyc] : 1'b0;
    if (stim_dac.exists(cyc)) dac_in <= stim_dac[cyc];
    if (cyc == 4) rst_n <= 1'b1;
  end

  // compare with the reference every cycle after reset
  always @(negedge clk) begin
    if (cyc == 3) begin
      check("R1", "tx_fs in reset", int'(tx_fs), 0);
      check("R1", "adc_valid in reset", int'(adc_valid), 0);
    end
    if (cyc >= 5 && !done) begin
      // R3 and R11: only the modelled pulses, none from later ring pulses
      check("R3 R11", "tx_fs", int'(tx_fs), exp_fs.exists(cyc) ? 1 : 0);
      check(exp_tag.exists(cyc) ? exp_tag[cyc] : "R1", "tx_data", int'(tx_data),
            exp_d.exists(cyc) ? int'(exp_d[cyc]) : 0);
      check(exp_v.exists(cyc) ? "R9" : "R10", "adc_valid", int'(adc_valid),
            exp_v.exists(cyc) ? 1 : 0);
      if (exp_v.exists(cyc) && adc_valid) begin
        check("R9", "adc_out", int'(adc_out), int'(exp_adc[cyc]));
        check("R9", "adc_chan", int'(adc_chan), exp_ch[cyc]);
      end
    end
  end

  initial begin
    // programming events, one with widened receive spacing
    add_event(20,  16, 16'h1234, 16'h5678, 32'h0);
    add_event(60,  20, 16'hFFFF, 16'h0000, 32'h0);
    add_event(100, 16, 16'hA5A5, 16'h5A5A, 32'h0);
    // data events; 140 -> 173 is the tightest legal spacing
    add_event(140, 16, 16'hFFFF, 16'h8001, 32'h1111_2222);
    add_event(173, 16, 16'h0000, 16'h7FFE, 32'hFFFF_0000);
    add_event(220, 25, 16'hC3C3, 16'h0F0F, 32'h8000_0001);
    add_event(270, 16, 16'h0001, 16'h8000, 32'hDEAD_BEEF);
    add_event(303, 16, 16'h1357, 16'h2468, 32'h0F0F_F0F0);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] v;
      v = 32'h9E37_79B9 * (k + 3);
      add_event(360 + 40 * k, 16 + k, v[31:16] ^ 16'h00FF, v[15:0], v ^ 32'h5555_AAAA);
    end
    wait (cyc >= end_cyc);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual no end expected end by cycle %0d", LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule